// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the fetch address for an 11-bit, 2K-word instruction store. The store is split into two pages of 1024 words. The address is held in one register. On each strobe the register advances by one, loads a 10-bit in-page target with the page bit from a status register above it, enters the interrupt vector, or takes a value back from a return stack. The return stack holds eight 11-bit levels. Calls and interrupt entries share it.

The stack is a ring. Pushing past eight levels overwrites the oldest entry. Popping more entries than were pushed wraps around the ring and never raises a fault. When an interrupt return is taken, a one-cycle flag goes out so that the surrounding core can turn its global interrupt enable back on.

More than one strobe may be raised in the same cycle. A fixed priority decides which one acts. The instruction decoder, the accumulator literal and interrupt masking are all outside this block.

Top module: `prog_counter_paged`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `fetchAddr` is 0x000, `intRetFlag` is 0 and the stack pointer is at slot 0. Every stack slot is cleared to 0x000.
- R2: When `advance` is the only strobe, `fetchAddr` becomes its old value plus one on the next edge, over all 11 bits. The value 0x7FF wraps to 0x000.
- R3: `jumpEn` loads `fetchAddr` with bit 10 = `pageSel` and bits 9..0 = `target`. The stack is not touched.
- R4: `callEn` pushes the old `fetchAddr` + 1 (11-bit wrap) and loads {`pageSel`, `target`} in the same way as R3.
- R5: `retEn` and `retLitEn` each pop the most recent stack entry into `fetchAddr`. The two strobes behave the same way.
- R6: `intEnter` pushes the old `fetchAddr` + 1 and loads the vector address 0x003.
- R7: `retIntEn` pops in the same way as R5. `intRetFlag` is 1 for exactly the one cycle that follows the edge on which that pop takes effect, and is 0 at all other times.
- R8: Priority, from highest to lowest: `intEnter`, `callEn`, `jumpEn`, any of the three return strobes, `advance`. Lower strobes in the same cycle have no effect. If no strobe is raised, `fetchAddr` holds its value.
- R9: The stack is a ring of 8 slots. After nine pushes P1..P9, nine pops return P9, P8, ..., P2 and then P9 again. A pop straight after reset returns 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Step to the next sequential address |
| jumpEn | input | 1 | Load the in-page target |
| callEn | input | 1 | Push the return address and load the in-page target |
| target | input | 10 | In-page target for a jump or call |
| pageSel | input | 1 | Page bit from the status register, becomes address bit 10 |
| retEn | input | 1 | Plain return (pop) |
| retLitEn | input | 1 | Return carrying a literal (pop) |
| retIntEn | input | 1 | Return from interrupt (pop plus flag) |
| intEnter | input | 1 | Interrupt entry (push plus vector) |
| fetchAddr | output | 11 | Current fetch address |
| intRetFlag | output | 1 | One-cycle pulse after a return from interrupt |

## Verification
The hardest state to reach from the ports is a stack that has overflowed. The pointer has wrapped, the oldest slot has been overwritten, and the pops then run back past the first entry. The stimulus reaches this state with a run of nine calls to known targets, so every pushed return address is predictable. It then makes nine returns and compares each one against a model kept in the bench. Priority collisions are driven as vectors that raise several strobes in the same cycle. A pop with no push before it is tested straight after a reset that is applied in the middle of the run.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic loadTarget;
    logic loadVector;
    logic inc;
  } pcStrobe_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      advance,
  input  logic      jumpEn,
  input  logic      callEn,
  input  logic      retEn,
  input  logic      retLitEn,
  input  logic      retIntEn,
  input  logic      intEnter,
  output pcStrobe_t strb,
  output logic      intRetFlag
);
  logic anyRet;
  logic retIntTaken;

  assign anyRet = retEn | retLitEn | retIntEn;

  // Fixed priority: interrupt, call, jump, return, advance
  always_comb begin
    strb = '0;
    if (intEnter) begin
      strb.push       = 1'b1;
      strb.loadVector = 1'b1;
    end else if (callEn) begin
      strb.push       = 1'b1;
      strb.loadTarget = 1'b1;
    end else if (jumpEn) begin
      strb.loadTarget = 1'b1;
    end else if (anyRet) begin
      strb.pop = 1'b1;
    end else if (advance) begin
      strb.inc = 1'b1;
    end
  end

  assign retIntTaken = retIntEn & ~(intEnter | callEn | jumpEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intRetFlag <= 1'b0;
    else       intRetFlag <= retIntTaken;
  end

  // R8: at most one kind of address load per cycle
  a_r8_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTarget, strb.loadVector, strb.pop, strb.inc}));
  // R8: a push never coincides with a pop
  a_r8_no_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !strb.pop);
  // R7: the flag only follows a cycle in which a pop was issued
  a_r7_flag_after_pop: assert property (@(posedge clk) disable iff (!rstN)
    intRetFlag |-> $past(strb.pop));
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PW    = 11,
  parameter int DEPTH = 8,
  parameter logic [PW-1:0] VEC = 11'h003
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcStrobe_t       strb,
  input  logic [PW-2:0]   target,
  input  logic            pageSel,
  output logic [PW-1:0]   pc
);
  localparam int SPW = $clog2(DEPTH);

  logic [PW-1:0]  stackMem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] spDec;
  logic [PW-1:0]  pcSeq;
  logic [PW-1:0]  pcNext;

  assign spDec = sp - SPW'(1);
  assign pcSeq = pc + PW'(1);

  always_comb begin
    if (strb.loadVector)      pcNext = VEC;
    else if (strb.loadTarget) pcNext = {pageSel, target};
    else if (strb.pop)        pcNext = stackMem[spDec];
    else if (strb.inc)        pcNext = pcSeq;
    else                      pcNext = pc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stackMem[i] <= '0;
    end else begin
      pc <= pcNext;
      if (strb.push) begin
        stackMem[sp] <= pcSeq;
        sp <= sp + SPW'(1);
      end else if (strb.pop) begin
        sp <= spDec;
      end
    end
  end

  // R2: a sequential step adds one, with wrap
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |=> pc == $past(pc) + PW'(1));
  // R3: a target load follows the page bit and the in-page target
  a_r3_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTarget |=> pc == {$past(pageSel), $past(target)});
  // R6: interrupt entry lands on the vector
  a_r6_vector: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadVector |=> pc == VEC);
  // R9: a push moves the ring pointer forward by one
  a_r9_ring_push: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> sp == $past(sp) + SPW'(1));
  // R8: with no strobe the address holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(pc));
endmodule

// File: rtl/prog_counter_paged.sv
module prog_counter_paged
  import pcs_pkg::*;
#(
  parameter int PW    = 11,
  parameter int DEPTH = 8,
  parameter logic [PW-1:0] VEC = 11'h003
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advance,
  input  logic          jumpEn,
  input  logic          callEn,
  input  logic [PW-2:0] target,
  input  logic          pageSel,
  input  logic          retEn,
  input  logic          retLitEn,
  input  logic          retIntEn,
  input  logic          intEnter,
  output logic [PW-1:0] fetchAddr,
  output logic          intRetFlag
);
  pcStrobe_t strb;

  pcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance), .jumpEn(jumpEn),
    .callEn(callEn), .retEn(retEn), .retLitEn(retLitEn),
    .retIntEn(retIntEn), .intEnter(intEnter), .strb(strb),
    .intRetFlag(intRetFlag)
  );

  pcs_datapath #(.PW(PW), .DEPTH(DEPTH), .VEC(VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .target(target),
    .pageSel(pageSel), .pc(fetchAddr)
  );
endmodule

// File: tb/prog_counter_paged_bench.sv
module prog_counter_paged_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 0, jumpEn = 0, callEn = 0, pageSel = 0;
  logic retEn = 0, retLitEn = 0, retIntEn = 0, intEnter = 0;
  logic [9:0]  target = '0;
  logic [10:0] fetchAddr;
  logic        intRetFlag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  prog_counter_paged u_prog_counter_paged (
    .clk(clk), .rstN(rstN), .advance(advance), .jumpEn(jumpEn),
    .callEn(callEn), .target(target), .pageSel(pageSel), .retEn(retEn),
    .retLitEn(retLitEn), .retIntEn(retIntEn), .intEnter(intEnter),
    .fetchAddr(fetchAddr), .intRetFlag(intRetFlag)
  );

  // strobes: adv jmp call ret retLit retInt intE page
  typedef struct packed {
    logic [7:0]  strobes;
    logic [9:0]  tgt;
    logic [10:0] expAddr;
    logic        expFlag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'b1000_0000, 10'h000, 11'h001, 1'b0},  // R2
    '{8'b1000_0000, 10'h000, 11'h002, 1'b0},  // R2
    '{8'b0100_0001, 10'h3FF, 11'h7FF, 1'b0},  // R3 page 1
    '{8'b1000_0000, 10'h000, 11'h000, 1'b0},  // R2 wrap
    '{8'b0100_0000, 10'h010, 11'h010, 1'b0},  // R3 page 0
    '{8'b0010_0001, 10'h020, 11'h420, 1'b0},  // R4 push 011
    '{8'b0010_0000, 10'h100, 11'h100, 1'b0},  // R4 push 421
    '{8'b0001_0000, 10'h000, 11'h421, 1'b0},  // R5 ret
    '{8'b0000_1000, 10'h000, 11'h011, 1'b0},  // R5 retLit
    '{8'b0000_0010, 10'h000, 11'h003, 1'b0},  // R6 push 012
    '{8'b1000_0000, 10'h000, 11'h004, 1'b0},  // R2
    '{8'b0000_0100, 10'h000, 11'h012, 1'b1},  // R7 pulse
    '{8'b0000_0000, 10'h000, 11'h012, 1'b0},  // R7 end, R8 hold
    '{8'b1110_0000, 10'h050, 11'h050, 1'b0},  // R8 call wins, push 013
    '{8'b0010_0011, 10'h000, 11'h003, 1'b0},  // R8 int wins, push 051
    '{8'b0101_0000, 10'h200, 11'h200, 1'b0},  // R8 jump over ret
    '{8'b1001_0000, 10'h000, 11'h051, 1'b0},  // R8 ret over adv
    '{8'b0000_0100, 10'h000, 11'h013, 1'b1}   // R7 pop
  };

  task automatic drive(input logic [7:0] s, input logic [9:0] t);
    {advance, jumpEn, callEn, retEn, retLitEn, retIntEn, intEnter, pageSel} = s;
    target = t;
  endtask

  task automatic chkAddr(input string req, input logic [10:0] exp);
    checks++;
    if (fetchAddr !== exp) begin
      errors++;
      $display("FAIL %s fetchAddr actual %h expected %h", req, fetchAddr, exp);
    end
  endtask

  task automatic chkFlag(input string req, input logic exp);
    checks++;
    if (intRetFlag !== exp) begin
      errors++;
      $display("FAIL %s intRetFlag actual %b expected %b", req, intRetFlag, exp);
    end
  endtask

  initial begin : watchdog
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [10:0] pushed [1:9];
    logic [10:0] model;
    repeat (3) @(negedge clk);
    chkAddr("R1", 11'h000);
    chkFlag("R1", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkAddr("R1", 11'h000);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].strobes, VECS[i].tgt);
      @(negedge clk);
      chkAddr($sformatf("vec%0d", i), VECS[i].expAddr);
      chkFlag($sformatf("vec%0d", i), VECS[i].expFlag);
    end

    // R9: nine calls overflow the ring
    model = fetchAddr;
    for (int i = 1; i <= 9; i++) begin
      pushed[i] = model + 11'd1;
      drive(8'b0010_0000, 10'(i * 32));
      model = 11'(i * 32);
      @(negedge clk);
    end
    chkAddr("R9 call", model);
    for (int k = 0; k < 8; k++) begin
      drive(8'b0001_0000, 10'h000);
      @(negedge clk);
      chkAddr("R9 pop", pushed[9 - k]);
    end
    drive(8'b0001_0000, 10'h000);
    @(negedge clk);
    chkAddr("R9 ring wrap", pushed[9]);

    // R1: reset in the middle of the run
    drive(8'b0000_0000, 10'h000);
    rstN = 1'b0;
    @(negedge clk);
    chkAddr("R1 mid", 11'h000);
    chkFlag("R1 mid", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: pop on an empty stack after reset returns zero
    drive(8'b1000_0000, 10'h000);
    @(negedge clk);
    chkAddr("R2 after reset", 11'h001);
    drive(8'b0000_0100, 10'h000);
    @(negedge clk);
    chkAddr("R9 empty pop", 11'h000);
    chkFlag("R7 empty pop", 1'b1);
    drive(8'b0000_0000, 10'h000);
    @(negedge clk);
    chkFlag("R7 single cycle", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule